// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the software-visible control and status register bank of a DMA engine that serves up to twelve channels. A host reaches it over a simple 32-bit memory-mapped bus: a write strobe, a byte offset, write data, and read data that follows the offset in the same cycle. Through it, software gives each channel a transfer mode and a direction, and chooses which channels may interrupt. It also reads each channel's completion and error flags together with the channel's current sequencer state.

Each channel sequencer drives three things into the block: a 2-bit state code, a one-cycle completion pulse and a one-cycle error pulse. The block returns each channel's mode and direction to its sequencer. It also drives a single interrupt line, which is high while any enabled channel has a completion flag pending. Channels 0 to 7 live in one pair of control and status words, and channels 8 to 11 live in a second pair. Within each pair, a channel's position is its number minus the first channel of that group.

Top module: `dmacsr_top`

## Requirements
- R1: After reset, every control word, the enable word, the spare word and every flag read as 0. All mode and direction outputs are 0, and the interrupt line is low.
- R2: Offset 0x00 holds channels 0..7. Channel n owns the nibble at bits [4n+3:4n]. Bits [1:0] of the nibble are the mode: 0 off, 1 linked descriptors, 2 single transfer. Bit 2 is the direction: 1 memory to device, 0 device to memory. Bit 3 reads 0. After a write, the channel's `ch_mode` and `ch_dir` outputs carry the new values from the next cycle on.
- R3: Offset 0x0C holds channels 8..11. Channel n uses the nibble at slot n-8, with the layout of R2. Bits [31:16] read 0. A write here leaves offset 0x00 untouched.
- R4: Offset 0x08 holds the interrupt enables. Channel n<8 uses bit n, and channel n>=8 uses bit n+8. All other bits read 0.
- R5: Offset 0x10 shows channels 0..7 and offset 0x18 shows channels 8..11, each indexed by slot i. Bit i is the completion flag and bit i+8 is the error flag. A completion pulse sets the completion flag. An error pulse sets both the error flag and the completion flag.
- R6: Writing 1 to a flag bit in a status word clears that flag. Writing 0 to a flag bit leaves it as it was.
- R7: If a set pulse and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R8: Bits [16+2i+1:16+2i] of a status word show the live `ch_state` code of slot i: 0 idle, 1 reading descriptor, 2 waiting, 3 moving data. Writes to a status word never change these bits.
- R9: `irq` is high exactly when some channel has both its completion flag and its enable bit set.
- R10: Offset 0x04 is a plain 32-bit read/write word. It keeps its value until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, committed at the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the word at `bus_addr`, combinational |
| ch_state | input | 2*NUM_CH | Live sequencer state code per channel |
| ch_done | input | NUM_CH | One-cycle completion pulse per channel |
| ch_err | input | NUM_CH | One-cycle error pulse per channel |
| ch_mode | output | 2*NUM_CH | Configured mode per channel |
| ch_dir | output | NUM_CH | Configured direction per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take the completion and error inputs to be pulses that are only meaningful outside reset. They also assume that a flag can rise only after such a pulse, and that the interrupt can rise only after a bus write or a pulse. The stimulus changes `ch_done`, `ch_err`, `ch_state` and the bus only at falling edges, and holds each pulse for exactly one cycle. It changes `ch_state` only while no status read is pending, so every read sees inputs that have settled. The one case where a pulse and a clear coincide is driven on purpose, in a single cycle.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

    localparam int MAX_CH    = 12;
    localparam int GROUP_CH  = 8;
    localparam int NIB_W     = 4;
    localparam int FLAG_OFS  = 8;
    localparam int STATE_OFS = 16;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_LINKED = 2'd1,
        MODE_SINGLE = 2'd2,
        MODE_RSVD   = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_MOVE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic       to_dev;
        xfer_mode_e mode;
    } chan_cfg_t;

    typedef enum logic [2:0] {
        W_CFG_LO  = 3'd0,
        W_SPARE   = 3'd1,
        W_IEN     = 3'd2,
        W_CFG_HI  = 3'd3,
        W_STAT_LO = 3'd4,
        W_STAT_MID = 3'd5,
        W_STAT_HI = 3'd6,
        W_NONE    = 3'd7
    } word_e;

    function automatic int slot_of(input int ch);
        return (ch < GROUP_CH) ? ch : ch - GROUP_CH;
    endfunction

    function automatic int ien_pos(input int ch);
        return (ch < GROUP_CH) ? ch : ch + FLAG_OFS;
    endfunction

endpackage

// File: rtl/dmacsr_chan_cfg.sv
module dmacsr_chan_cfg
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_lo,
    input  logic                     wr_hi,
    input  logic                     wr_ien,
    input  logic [31:0]              wdata,
    output chan_cfg_t [NUM_CH-1:0]   cfg_q,
    output logic      [NUM_CH-1:0]   ien_q
);

    logic wdata_unused;
    assign wdata_unused = ^wdata;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int BASE = NIB_W * slot_of(n);
        localparam int EPOS = ien_pos(n);
        logic sel;

        if (n >= GROUP_CH) begin : g_hi
            assign sel = wr_hi;
        end else begin : g_lo
            assign sel = wr_lo;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[n] <= '0;
                ien_q[n] <= 1'b0;
            end else begin
                if (sel)
                    cfg_q[n] <= chan_cfg_t'(wdata[BASE +: 3]);
                if (wr_ien)
                    ien_q[n] <= wdata[EPOS];
            end
        end
    end

endmodule

// File: rtl/dmacsr_flags.sv
module dmacsr_flags
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_lo,
    input  logic              clr_hi,
    input  logic [31:0]       wdata,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_err,
    output logic [NUM_CH-1:0] done_q,
    output logic [NUM_CH-1:0] err_q
);

    logic wdata_unused;
    assign wdata_unused = ^wdata;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int SLOT = slot_of(n);
        logic sel;
        logic kill_done;
        logic kill_err;

        if (n >= GROUP_CH) begin : g_hi
            assign sel = clr_hi;
        end else begin : g_lo
            assign sel = clr_lo;
        end

        assign kill_done = sel && wdata[SLOT];
        assign kill_err  = sel && wdata[SLOT + FLAG_OFS];

        // a set pulse overrides a clear in the same cycle
        always_ff @(posedge clk) begin
            if (rst) begin
                done_q[n] <= 1'b0;
                err_q[n]  <= 1'b0;
            end else begin
                done_q[n] <= ch_done[n] | ch_err[n] | (done_q[n] & ~kill_done);
                err_q[n]  <= ch_err[n] | (err_q[n] & ~kill_err);
            end
        end
    end

endmodule

// File: rtl/dmacsr_rdmux.sv
module dmacsr_rdmux
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input  word_e                   word,
    input  chan_cfg_t [NUM_CH-1:0]  cfg_q,
    input  logic      [NUM_CH-1:0]  ien_q,
    input  logic      [31:0]        spare_q,
    input  logic      [NUM_CH-1:0]  done_q,
    input  logic      [NUM_CH-1:0]  err_q,
    input  logic      [2*NUM_CH-1:0] ch_state,
    output logic      [31:0]        rdata
);

    localparam int LO_CH = (NUM_CH < GROUP_CH) ? NUM_CH : GROUP_CH;
    localparam int HI_CH = (NUM_CH > GROUP_CH) ? NUM_CH - GROUP_CH : 0;

    always_comb begin
        rdata = '0;
        unique case (word)
            W_CFG_LO: begin
                for (int n = 0; n < LO_CH; n++)
                    rdata[NIB_W*n +: 3] = cfg_q[n];
            end
            W_CFG_HI: begin
                for (int m = 0; m < HI_CH; m++)
                    rdata[NIB_W*m +: 3] = cfg_q[m + GROUP_CH];
            end
            W_SPARE: rdata = spare_q;
            W_IEN: begin
                for (int n = 0; n < NUM_CH; n++)
                    rdata[ien_pos(n)] = ien_q[n];
            end
            W_STAT_LO: begin
                for (int n = 0; n < LO_CH; n++) begin
                    rdata[n]                   = done_q[n];
                    rdata[n + FLAG_OFS]        = err_q[n];
                    rdata[STATE_OFS + 2*n +: 2] = ch_state[2*n +: 2];
                end
            end
            W_STAT_HI: begin
                for (int m = 0; m < HI_CH; m++) begin
                    rdata[m]                   = done_q[m + GROUP_CH];
                    rdata[m + FLAG_OFS]        = err_q[m + GROUP_CH];
                    rdata[STATE_OFS + 2*m +: 2] = ch_state[2*(m + GROUP_CH) +: 2];
                end
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmacsr_top.sv
module dmacsr_top
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [2*NUM_CH-1:0]   ch_state,
    input  logic [NUM_CH-1:0]     ch_done,
    input  logic [NUM_CH-1:0]     ch_err,
    output logic [2*NUM_CH-1:0]   ch_mode,
    output logic [NUM_CH-1:0]     ch_dir,
    output logic                  irq
);

    chan_cfg_t [NUM_CH-1:0] cfg_q;
    logic [NUM_CH-1:0] ien_q;
    logic [NUM_CH-1:0] done_q;
    logic [NUM_CH-1:0] err_q;
    logic [31:0]       spare_q;
    logic              in_range;
    word_e             word;
    logic              addr_unused;

    assign addr_unused = ^bus_addr[1:0];
    assign in_range    = (bus_addr >> 5) == '0;
    assign word        = in_range ? word_e'(bus_addr[4:2]) : W_NONE;

    dmacsr_chan_cfg #(.NUM_CH(NUM_CH)) cfg_i (
        .clk    (clk),
        .rst    (rst),
        .wr_lo  (bus_wr && word == W_CFG_LO),
        .wr_hi  (bus_wr && word == W_CFG_HI),
        .wr_ien (bus_wr && word == W_IEN),
        .wdata  (bus_wdata),
        .cfg_q  (cfg_q),
        .ien_q  (ien_q)
    );

    dmacsr_flags #(.NUM_CH(NUM_CH)) flags_i (
        .clk     (clk),
        .rst     (rst),
        .clr_lo  (bus_wr && word == W_STAT_LO),
        .clr_hi  (bus_wr && word == W_STAT_HI),
        .wdata   (bus_wdata),
        .ch_done (ch_done),
        .ch_err  (ch_err),
        .done_q  (done_q),
        .err_q   (err_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            spare_q <= '0;
        else if (bus_wr && word == W_SPARE)
            spare_q <= bus_wdata;
    end

    dmacsr_rdmux #(.NUM_CH(NUM_CH)) rdmux_i (
        .word     (word),
        .cfg_q    (cfg_q),
        .ien_q    (ien_q),
        .spare_q  (spare_q),
        .done_q   (done_q),
        .err_q    (err_q),
        .ch_state (ch_state),
        .rdata    (bus_rdata)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_out
        assign ch_mode[2*n +: 2] = cfg_q[n].mode;
        assign ch_dir[n]         = cfg_q[n].to_dev;
    end

    assign irq = |(done_q & ien_q);

endmodule

// File: rtl/dmacsr_chk.sv
module dmacsr_chk #(
    parameter int NUM_CH = 12,
    parameter int ADDR_W = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_rdata,
    input logic [2*NUM_CH-1:0] ch_state,
    input logic [NUM_CH-1:0]   ch_done,
    input logic [NUM_CH-1:0]   ch_err,
    input logic [2*NUM_CH-1:0] ch_mode,
    input logic [NUM_CH-1:0]   ch_dir,
    input logic                irq,
    input logic [NUM_CH-1:0]   done_q,
    input logic [NUM_CH-1:0]   err_q,
    input logic [31:0]         spare_q
);

    logic past_rst = 1'b0;

    always @(posedge clk) begin
        if (past_rst) begin
            // R1
            reset_clear_chk: assert (!irq && ch_mode == '0 && ch_dir == '0 &&
                                     done_q == '0 && err_q == '0 && spare_q == '0)
                else $error("state not cleared by reset");
        end
        past_rst <= rst;
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        // R5
        done_set_chk: assert property (@(posedge clk) disable iff (rst)
            (ch_done[n] || ch_err[n]) |=> done_q[n])
            else $error("completion flag not set");

        // R5
        err_set_chk: assert property (@(posedge clk) disable iff (rst)
            ch_err[n] |=> (err_q[n] && done_q[n]))
            else $error("error flag not set");

        // R6
        flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(done_q[n]) |-> $past(ch_done[n] || ch_err[n]))
            else $error("flag rose without a pulse");
    end

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(bus_wr) || $past(|(ch_done | ch_err))))
        else $error("interrupt rose without cause");

    // R10
    spare_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == ADDR_W'(4)) |=> $stable(spare_q))
        else $error("spare word changed without write");

    // R8
    state_view_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(16)) |-> (bus_rdata[17:16] == ch_state[1:0]))
        else $error("state field mismatch");

endmodule

bind dmacsr_top dmacsr_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dmacsr_top_tb_top.sv
`timescale 1ns/1ps
module dmacsr_top_tb_top;

    localparam int NUM_CH = 12;
    localparam int ADDR_W = 5;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                bus_wr = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [2*NUM_CH-1:0] ch_state = '0;
    logic [NUM_CH-1:0]   ch_done = '0;
    logic [NUM_CH-1:0]   ch_err = '0;
    logic [2*NUM_CH-1:0] ch_mode;
    logic [NUM_CH-1:0]   ch_dir;
    logic                irq;

    always #4 clk = ~clk;

    dmacsr_top #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut_i (.*);

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done_run = 0;

    logic [11:0] dm = '0;
    logic [11:0] em = '0;

    function automatic logic [31:0] sts_lo();
        return {ch_state[15:0], em[7:0], dm[7:0]};
    endfunction

    function automatic logic [31:0] sts_hi();
        return {8'h00, ch_state[23:16], 4'h0, em[11:8], 4'h0, dm[11:8]};
    endfunction

    // monitor: compare queued expectations away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                exp_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = {31'h0, irq};
                    2: act = 32'(ch_mode);
                    default: act = 32'(ch_dir);
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic exp_rd(input logic [31:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = ADDR_W'(a);
        it.kind = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(posedge clk);
    endtask

    task automatic exp_out(input int k, input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        it.kind = k; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(posedge clk);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        if (a == 32'h10) begin dm[7:0]  &= ~d[7:0];  em[7:0]  &= ~d[15:8]; end
        if (a == 32'h18) begin dm[11:8] &= ~d[3:0];  em[11:8] &= ~d[11:8]; end
    endtask

    task automatic pulse(input logic [11:0] d, input logic [11:0] e);
        @(negedge clk);
        ch_done = d;
        ch_err  = e;
        @(negedge clk);
        ch_done = '0;
        ch_err  = '0;
        dm |= d | e;
        em |= e;
    endtask

    initial begin
        #800000;
        if (!done_run) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        exp_rd(32'h00, 32'h0, "R1 cfg lo");
        exp_rd(32'h04, 32'h0, "R1 spare");
        exp_rd(32'h08, 32'h0, "R1 ien");
        exp_rd(32'h0C, 32'h0, "R1 cfg hi");
        exp_rd(32'h10, 32'h0, "R1 stat lo");
        exp_rd(32'h18, 32'h0, "R1 stat hi");
        exp_out(1, 32'h0, "R1 irq");
        exp_out(2, 32'h0, "R1 mode");

        // R2 low control word
        wr(32'h00, 32'hFFFF_FFFF);
        exp_rd(32'h00, 32'h7777_7777, "R2 all ones");
        exp_out(2, 32'h0000_FFFF, "R2 mode all");
        exp_out(3, 32'h0000_00FF, "R2 dir all");
        wr(32'h00, 32'h0000_0061);
        exp_rd(32'h00, 32'h0000_0061, "R2 pattern");
        exp_out(2, 32'h0000_0009, "R2 mode pattern");
        exp_out(3, 32'h0000_0002, "R2 dir pattern");

        // R3 high control word
        wr(32'h0C, 32'hFFFF_FFFF);
        exp_rd(32'h0C, 32'h0000_7777, "R3 all ones");
        exp_rd(32'h00, 32'h0000_0061, "R3 low untouched");
        exp_out(2, 32'h00FF_0009, "R3 mode all");
        exp_out(3, 32'h0000_0F02, "R3 dir all");
        wr(32'h0C, 32'h0000_0502);
        exp_rd(32'h0C, 32'h0000_0502, "R3 pattern");
        exp_out(2, 32'h0012_0009, "R3 mode pattern");
        exp_out(3, 32'h0000_0402, "R3 dir pattern");

        // R4 enable word
        wr(32'h08, 32'hFFFF_FFFF);
        exp_rd(32'h08, 32'h000F_00FF, "R4 enable map");
        wr(32'h08, 32'h0);
        exp_rd(32'h08, 32'h0, "R4 enable clear");

        // R10 spare word
        wr(32'h04, 32'hA5A5_1234);
        wr(32'h00, 32'h0000_0061);
        exp_rd(32'h04, 32'hA5A5_1234, "R10 retained");

        // R8 live state
        @(negedge clk);
        ch_state = 24'hD2C5A7;
        exp_rd(32'h10, sts_lo(), "R8 state lo");
        exp_rd(32'h18, sts_hi(), "R8 state hi");
        wr(32'h10, 32'hFFFF_0000);
        exp_rd(32'h10, sts_lo(), "R8 write ignored");

        // R5 set by pulses
        pulse(12'h208, 12'h820);
        exp_rd(32'h10, sts_lo(), "R5 stat lo");
        exp_rd(32'h18, sts_hi(), "R5 stat hi");
        exp_out(1, 32'h0, "R9 no enable");

        // R9 enable ch9
        wr(32'h08, 32'h0002_0000);
        exp_out(1, 32'h1, "R9 irq on");

        // R6 write-one-to-clear
        wr(32'h18, 32'h0000_0002);
        exp_out(1, 32'h0, "R9 irq off after clear");
        exp_rd(32'h18, sts_hi(), "R6 clear ch9");
        wr(32'h10, 32'h0);
        exp_rd(32'h10, sts_lo(), "R6 zero write");
        wr(32'h10, 32'h0000_2008);
        exp_rd(32'h10, sts_lo(), "R6 clear ch3 done ch5 err");

        // R7 set wins
        @(negedge clk);
        bus_addr  = ADDR_W'(32'h10);
        bus_wdata = 32'h0000_0001;
        bus_wr    = 1'b1;
        ch_done   = 12'h001;
        @(negedge clk);
        bus_wr    = 1'b0;
        ch_done   = '0;
        dm[0]     = 1'b1;
        exp_rd(32'h10, sts_lo(), "R7 set beats clear");

        // R9 enable ch5
        wr(32'h08, 32'h0000_0020);
        exp_out(1, 32'h1, "R9 irq ch5");

        repeat (3) @(negedge clk);
        done_run = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule